// File: doc/BRIEF.md
# Instruction Fetch Memory Router

This block connects a processor's fetch stage to its instruction memories. Each fetch request carries a byte address. The block compares that address against up to four tightly-coupled memory windows. If the address falls inside an enabled window, the fetch goes to that window's memory port and the cache never sees it. Every other fetch goes to an instruction cache lookup port. When the cache path is removed by parameter, a fetch that misses every window comes back with a bus error. Each window's base and size come from parameters. A size is a power of two, and its base must be aligned to it, so each window test is one mask and one compare.

The fetch request and the fetch response are both valid/ready streams, and only one fetch may be in flight. The request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the router is idle. The response holds `rsp_valid`, `rsp_data` and `rsp_err` unchanged until a cycle where `rsp_ready` is high, so the fetch stage may stall the router for any number of cycles. The cache request is also valid/ready, and the cache answers with a single-cycle `ic_rsp_valid` pulse.

Cache line initialize and line flush requests pass through a registered filter. The filter drops any request that targets an enabled window. It aligns every other request to a 32-byte line and passes it to the cache one cycle later. Elaboration stops with an error if the cache is disabled and no window is enabled.

Top module: `ifetch_router`

## Requirements
- R1: A fetch that hits an enabled window raises only that port's `tcm_rd` bit, in the cycle the request is accepted. `tcm_addr` carries the address bits below the window size. The response appears two cycles after the accepting edge with the word that port returned one cycle after the strobe, and with `rsp_err` = 0.
- R2: `ic_req_valid` stays low for the whole of a fetch that hits a window.
- R3: When enabled windows overlap, the port with the lowest index takes the fetch.
- R4: A fetch that hits no window, with the cache present, raises `ic_req_valid` with the full fetch address. Valid and address stay stable until `ic_req_ready`. The response carries the data of the next `ic_rsp_valid` pulse, with `rsp_err` = 0.
- R5: The window of a disabled port is not decoded. Fetches and maintenance requests aimed at it go to the cache.
- R6: With the cache absent, a fetch that hits no window raises no strobe. It returns `rsp_err` = 1 and `rsp_data` = 0, one cycle after the accepting edge.
- R7: `req_ready` is low from the accepting edge until the response has been taken.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the response stays valid and `rsp_data` and `rsp_err` do not change.
- R9: A maintenance request outside every enabled window shows up on `ic_mnt_*` one cycle later. The operation bit is unchanged (0 = line initialize, 1 = line flush) and address bits 4:0 are cleared.
- R10: A maintenance request inside an enabled window is dropped, and `ic_mnt_valid` stays low the next cycle.
- R11: With the cache absent, `ic_req_valid` and `ic_mnt_valid` never rise.
- R12: Out of reset, `req_ready` = 1 and `rsp_valid`, `tcm_rd`, `ic_req_valid` and `ic_mnt_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Router idle, can take a fetch |
| req_addr | input | ADDR_W | Fetch byte address |
| rsp_valid | output | 1 | Fetch response valid |
| rsp_ready | input | 1 | Fetch stage takes the response |
| rsp_data | output | DATA_W | Instruction word |
| rsp_err | output | 1 | Bus error, no memory holds the address |
| tcm_rd | output | NUM_TCM | Per-port read strobe |
| tcm_addr | output | NUM_TCM x ADDR_W | Per-port offset inside the window |
| tcm_rdata | input | NUM_TCM x DATA_W | Per-port read data, one cycle after the strobe |
| ic_req_valid | output | 1 | Cache lookup request valid |
| ic_req_ready | input | 1 | Cache takes the lookup |
| ic_req_addr | output | ADDR_W | Cache lookup address |
| ic_rsp_valid | input | 1 | Cache data pulse |
| ic_rsp_data | input | DATA_W | Cache data |
| mreq_valid | input | 1 | Maintenance request strobe |
| mreq_op | input | 1 | 0 = line initialize, 1 = line flush |
| mreq_addr | input | ADDR_W | Maintenance byte address |
| ic_mnt_valid | output | 1 | Filtered maintenance strobe to the cache |
| ic_mnt_op | output | 1 | Filtered operation |
| ic_mnt_addr | output | ADDR_W | Line-aligned maintenance address |

## Verification
The assertions check the per-cycle rules on every cycle: at most one port strobe, no cache request right after a window strobe, `req_ready` low while a response waits, a stable response and a stable cache request under back-pressure, and maintenance requests forwarded or dropped according to the window decode. Some behaviour only the bench scenarios can show, because it depends on the address values: which port a given address reaches (including the window edges, overlapping windows and disabled ports), the offset and data each port returns, the exact response latency for each path, the error response when the cache is absent, and the aligned maintenance address.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  localparam int LINE_OFF_W = 5;
  localparam int MAX_TCM    = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TCM,
    ST_CREQ,
    ST_CWAIT,
    ST_RESP
  } ifr_state_e;
endpackage

// File: rtl/ifr_range_decode.sv
module ifr_range_decode #(
  parameter int ADDR_W  = 31,
  parameter int NUM_TCM = 4,
  parameter logic [NUM_TCM-1:0]             TCM_EN   = '1,
  parameter logic [NUM_TCM-1:0][ADDR_W-1:0] TCM_BASE = '0,
  parameter logic [NUM_TCM-1:0][7:0]        TCM_LG   = '0
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_TCM-1:0] grant
);
  logic [NUM_TCM-1:0] raw;

  for (genvar k = 0; k < NUM_TCM; k++) begin : g_win
    localparam logic [ADDR_W-1:0] MASK = {ADDR_W{1'b1}} << TCM_LG[k];
    if (TCM_EN[k]) begin : g_on
      if ((TCM_BASE[k] & ~MASK) != '0) begin : g_misaligned
        $error("window base not aligned to its size");
      end
      if (TCM_LG[k] >= ADDR_W) begin : g_too_big
        $error("window size exceeds address space");
      end
      assign raw[k] = ((addr & MASK) == TCM_BASE[k]);
    end else begin : g_off
      assign raw[k] = 1'b0;
    end
  end

  // lowest index wins when windows overlap
  always_comb begin : p_prio
    logic taken;
    taken = 1'b0;
    for (int k = 0; k < NUM_TCM; k++) begin
      grant[k] = raw[k] & ~taken;
      taken    = taken | raw[k];
    end
  end
endmodule

// File: rtl/ifr_maint_filter.sv
module ifr_maint_filter
  import ifr_pkg::*;
#(
  parameter int ADDR_W   = 31,
  parameter int NUM_TCM  = 4,
  parameter bit CACHE_EN = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         mreq_valid,
  input  logic                         mreq_op,
  input  logic [ADDR_W-LINE_OFF_W-1:0] mreq_line,
  input  logic [NUM_TCM-1:0]           win_grant,
  output logic                         ic_mnt_valid,
  output logic                         ic_mnt_op,
  output logic [ADDR_W-1:0]            ic_mnt_addr
);
  logic in_window;
  assign in_window = |win_grant;

  if (CACHE_EN) begin : g_fwd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ic_mnt_valid <= 1'b0;
        ic_mnt_op    <= 1'b0;
        ic_mnt_addr  <= '0;
      end else begin
        ic_mnt_valid <= mreq_valid & ~in_window;
        if (mreq_valid && !in_window) begin
          ic_mnt_op   <= mreq_op;
          ic_mnt_addr <= {mreq_line, {LINE_OFF_W{1'b0}}};
        end
      end
    end

    // R9
    mnt_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq_valid && !in_window) |=> (ic_mnt_valid && ic_mnt_op == $past(mreq_op)));
  end else begin : g_none
    assign ic_mnt_valid = 1'b0;
    assign ic_mnt_op    = 1'b0;
    assign ic_mnt_addr  = '0;
  end

  // R10
  mnt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && in_window) |=> !ic_mnt_valid);
endmodule

// File: rtl/ifr_fetch_ctrl.sv
module ifr_fetch_ctrl
  import ifr_pkg::*;
#(
  parameter int ADDR_W   = 31,
  parameter int DATA_W   = 32,
  parameter int NUM_TCM  = 4,
  parameter bit CACHE_EN = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic [NUM_TCM-1:0]             win_grant,
  output logic                           rsp_valid,
  input  logic                           rsp_ready,
  output logic [DATA_W-1:0]              rsp_data,
  output logic                           rsp_err,
  output logic [NUM_TCM-1:0]             tcm_rd,
  input  logic [NUM_TCM-1:0][DATA_W-1:0] tcm_rdata,
  output logic                           ic_req_valid,
  input  logic                           ic_req_ready,
  output logic [ADDR_W-1:0]              ic_req_addr,
  input  logic                           ic_rsp_valid,
  input  logic [DATA_W-1:0]              ic_rsp_data
);
  localparam int SEL_W = (NUM_TCM > 1) ? $clog2(NUM_TCM) : 1;

  ifr_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [DATA_W-1:0] data_q;
  logic              err_q;
  logic              accept, hit;

  assign hit    = |win_grant;
  assign accept = req_valid & (state_q == ST_IDLE);

  always_comb begin
    sel_d = '0;
    for (int k = NUM_TCM - 1; k >= 0; k--) begin
      if (win_grant[k]) sel_d = SEL_W'(k);
    end
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (hit)           state_d = ST_TCM;
          else if (CACHE_EN) state_d = ST_CREQ;
          else               state_d = ST_RESP;
        end
      end
      ST_TCM:   state_d = ST_RESP;
      ST_CREQ:  if (ic_req_ready) state_d = ST_CWAIT;
      ST_CWAIT: if (ic_rsp_valid) state_d = ST_RESP;
      ST_RESP:  if (rsp_ready)    state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      sel_q   <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= req_addr;
        sel_q  <= sel_d;
        if (!hit && !CACHE_EN) begin
          data_q <= '0;
          err_q  <= 1'b1;
        end
      end
      if (state_q == ST_TCM) begin
        data_q <= tcm_rdata[sel_q];
        err_q  <= 1'b0;
      end
      if (state_q == ST_CWAIT && ic_rsp_valid) begin
        data_q <= ic_rsp_data;
        err_q  <= 1'b0;
      end
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign tcm_rd       = accept ? win_grant : '0;
  assign rsp_valid    = (state_q == ST_RESP);
  assign rsp_data     = data_q;
  assign rsp_err      = err_q;
  assign ic_req_valid = CACHE_EN && (state_q == ST_CREQ);
  assign ic_req_addr  = addr_q;

  // R1
  tcm_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tcm_rd));
  // R2
  tcm_no_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tcm_rd) |=> !ic_req_valid);
  // R7
  single_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));
  // R4
  creq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ic_req_valid && !ic_req_ready) |=> (ic_req_valid && $stable(ic_req_addr)));
endmodule

// File: rtl/ifetch_router.sv
module ifetch_router
  import ifr_pkg::*;
#(
  parameter int ADDR_W   = 31,
  parameter int DATA_W   = 32,
  parameter int NUM_TCM  = 4,
  parameter bit CACHE_EN = 1'b1,
  parameter logic [NUM_TCM-1:0]             TCM_EN   = 4'b0111,
  parameter logic [NUM_TCM-1:0][ADDR_W-1:0] TCM_BASE =
    {31'h0020_0000, 31'h0010_0000, 31'h0001_0000, 31'h0000_0000},
  parameter logic [NUM_TCM-1:0][7:0]        TCM_LG   = {8'd12, 8'd10, 8'd14, 8'd12}
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic [ADDR_W-1:0]              req_addr,
  output logic                           rsp_valid,
  input  logic                           rsp_ready,
  output logic [DATA_W-1:0]              rsp_data,
  output logic                           rsp_err,
  output logic [NUM_TCM-1:0]             tcm_rd,
  output logic [NUM_TCM-1:0][ADDR_W-1:0] tcm_addr,
  input  logic [NUM_TCM-1:0][DATA_W-1:0] tcm_rdata,
  output logic                           ic_req_valid,
  input  logic                           ic_req_ready,
  output logic [ADDR_W-1:0]              ic_req_addr,
  input  logic                           ic_rsp_valid,
  input  logic [DATA_W-1:0]              ic_rsp_data,
  input  logic                           mreq_valid,
  input  logic                           mreq_op,
  input  logic [ADDR_W-1:0]              mreq_addr,
  output logic                           ic_mnt_valid,
  output logic                           ic_mnt_op,
  output logic [ADDR_W-1:0]              ic_mnt_addr
);
  if (NUM_TCM < 1 || NUM_TCM > MAX_TCM) begin : g_bad_count
    $error("NUM_TCM must be between 1 and 4");
  end
  if (!CACHE_EN && TCM_EN == '0) begin : g_no_memory
    $error("cache disabled requires at least one enabled window");
  end

  logic [NUM_TCM-1:0] fetch_grant, mnt_grant;

  ifr_range_decode #(
    .ADDR_W(ADDR_W), .NUM_TCM(NUM_TCM),
    .TCM_EN(TCM_EN), .TCM_BASE(TCM_BASE), .TCM_LG(TCM_LG)
  ) u_fetch_dec (
    .addr  (req_addr),
    .grant (fetch_grant)
  );

  ifr_range_decode #(
    .ADDR_W(ADDR_W), .NUM_TCM(NUM_TCM),
    .TCM_EN(TCM_EN), .TCM_BASE(TCM_BASE), .TCM_LG(TCM_LG)
  ) u_mnt_dec (
    .addr  (mreq_addr),
    .grant (mnt_grant)
  );

  for (genvar k = 0; k < NUM_TCM; k++) begin : g_off
    localparam logic [ADDR_W-1:0] KEEP = ~({ADDR_W{1'b1}} << TCM_LG[k]);
    if (TCM_EN[k]) begin : g_on
      assign tcm_addr[k] = req_addr & KEEP;
    end else begin : g_idle
      assign tcm_addr[k] = '0;
    end
  end

  ifr_fetch_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_TCM(NUM_TCM), .CACHE_EN(CACHE_EN)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .win_grant    (fetch_grant),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_data     (rsp_data),
    .rsp_err      (rsp_err),
    .tcm_rd       (tcm_rd),
    .tcm_rdata    (tcm_rdata),
    .ic_req_valid (ic_req_valid),
    .ic_req_ready (ic_req_ready),
    .ic_req_addr  (ic_req_addr),
    .ic_rsp_valid (ic_rsp_valid),
    .ic_rsp_data  (ic_rsp_data)
  );

  ifr_maint_filter #(
    .ADDR_W(ADDR_W), .NUM_TCM(NUM_TCM), .CACHE_EN(CACHE_EN)
  ) u_mfilt (
    .clk          (clk),
    .rst_n        (rst_n),
    .mreq_valid   (mreq_valid),
    .mreq_op      (mreq_op),
    .mreq_line    (mreq_addr[ADDR_W-1:LINE_OFF_W]),
    .win_grant    (mnt_grant),
    .ic_mnt_valid (ic_mnt_valid),
    .ic_mnt_op    (ic_mnt_op),
    .ic_mnt_addr  (ic_mnt_addr)
  );

  // R11
  no_cache_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !CACHE_EN |-> (!ic_req_valid && !ic_mnt_valid));
endmodule

// File: tb/tb_ifetch_router.sv
module tb_ifetch_router;
  localparam int AW = 31;
  localparam int DW = 32;
  localparam int NT = 4;
  localparam logic [NT-1:0] EN_A = 4'b0111;
  localparam logic [NT-1:0][AW-1:0] BASE_A =
    {31'h0020_0000, 31'h0010_0000, 31'h0001_0000, 31'h0000_0000};
  localparam logic [NT-1:0][7:0] LG_A = {8'd12, 8'd10, 8'd14, 8'd12};
  localparam int LGI_A [NT] = '{12, 14, 10, 12};
  localparam logic [NT-1:0] EN_B = 4'b0011;
  localparam logic [NT-1:0][AW-1:0] BASE_B = '0;
  localparam logic [NT-1:0][7:0] LG_B = {8'd4, 8'd4, 8'd16, 8'd12};

  // {addr, kind (0 window, 1 cache), port}
  localparam logic [34:0] VEC [9] = '{
    {31'h0000_0004, 2'd0, 2'd0},
    {31'h0000_0FFC, 2'd0, 2'd0},
    {31'h0000_1000, 2'd1, 2'd0},
    {31'h0001_0000, 2'd0, 2'd1},
    {31'h0001_3FFC, 2'd0, 2'd1},
    {31'h0010_03FC, 2'd0, 2'd2},
    {31'h0020_0010, 2'd1, 2'd0},
    {31'h7FFF_FFFC, 2'd1, 2'd0},
    {31'h0000_FFFC, 2'd1, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req_valid = 1'b0, req_ready, rsp_valid, rsp_ready = 1'b1, rsp_err;
  logic [AW-1:0] req_addr = '0, ic_req_addr, ic_mnt_addr, mreq_addr = '0;
  logic [DW-1:0] rsp_data, ic_rsp_data;
  logic [NT-1:0] tcm_rd;
  logic [NT-1:0][AW-1:0] tcm_addr;
  logic [NT-1:0][DW-1:0] tcm_rdata;
  logic ic_req_valid, ic_req_ready, ic_rsp_valid;
  logic mreq_valid = 1'b0, mreq_op = 1'b0, ic_mnt_valid, ic_mnt_op;

  logic n_req_valid = 1'b0, n_req_ready, n_rsp_valid, n_rsp_err;
  logic [AW-1:0] n_req_addr = '0, n_ic_req_addr, n_ic_mnt_addr, n_mreq_addr = '0;
  logic [DW-1:0] n_rsp_data;
  logic [NT-1:0] n_tcm_rd;
  logic [NT-1:0][AW-1:0] n_tcm_addr;
  logic [NT-1:0][DW-1:0] n_tcm_rdata;
  logic n_ic_req_valid, n_mreq_valid = 1'b0, n_ic_mnt_valid, n_ic_mnt_op;

  ifetch_router #(.ADDR_W(AW), .DATA_W(DW), .NUM_TCM(NT), .CACHE_EN(1'b1),
    .TCM_EN(EN_A), .TCM_BASE(BASE_A), .TCM_LG(LG_A)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .tcm_rd(tcm_rd), .tcm_addr(tcm_addr),
    .tcm_rdata(tcm_rdata), .ic_req_valid(ic_req_valid), .ic_req_ready(ic_req_ready),
    .ic_req_addr(ic_req_addr), .ic_rsp_valid(ic_rsp_valid), .ic_rsp_data(ic_rsp_data),
    .mreq_valid(mreq_valid), .mreq_op(mreq_op), .mreq_addr(mreq_addr),
    .ic_mnt_valid(ic_mnt_valid), .ic_mnt_op(ic_mnt_op), .ic_mnt_addr(ic_mnt_addr));

  ifetch_router #(.ADDR_W(AW), .DATA_W(DW), .NUM_TCM(NT), .CACHE_EN(1'b0),
    .TCM_EN(EN_B), .TCM_BASE(BASE_B), .TCM_LG(LG_B)) dut_nc (
    .clk(clk), .rst_n(rst_n), .req_valid(n_req_valid), .req_ready(n_req_ready),
    .req_addr(n_req_addr), .rsp_valid(n_rsp_valid), .rsp_ready(1'b1),
    .rsp_data(n_rsp_data), .rsp_err(n_rsp_err), .tcm_rd(n_tcm_rd), .tcm_addr(n_tcm_addr),
    .tcm_rdata(n_tcm_rdata), .ic_req_valid(n_ic_req_valid), .ic_req_ready(1'b0),
    .ic_req_addr(n_ic_req_addr), .ic_rsp_valid(1'b0), .ic_rsp_data('0),
    .mreq_valid(n_mreq_valid), .mreq_op(1'b1), .mreq_addr(n_mreq_addr),
    .ic_mnt_valid(n_ic_mnt_valid), .ic_mnt_op(n_ic_mnt_op), .ic_mnt_addr(n_ic_mnt_addr));

  function automatic logic [31:0] tword(int k, logic [AW-1:0] off);
    return 32'hA000_0000 | (32'(k) << 24) | {1'b0, off};
  endfunction
  function automatic logic [31:0] cword(logic [AW-1:0] a);
    return {1'b0, a} ^ 32'hC3C3_0000;
  endfunction

  // memory models
  always @(posedge clk) begin
    for (int k = 0; k < NT; k++) begin
      tcm_rdata[k]   <= tcm_rd[k]   ? tword(k, tcm_addr[k])   : 32'hDEAD_BEEF;
      n_tcm_rdata[k] <= n_tcm_rd[k] ? tword(k, n_tcm_addr[k]) : 32'hDEAD_BEEF;
    end
  end

  logic          c_pend;
  int            c_cnt;
  logic [AW-1:0] c_addr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ic_req_ready <= 1'b0; c_pend <= 1'b0; c_cnt <= 0; c_addr <= '0;
      ic_rsp_valid <= 1'b0; ic_rsp_data <= '0;
    end else begin
      ic_rsp_valid <= 1'b0;
      if (c_pend) begin
        if (c_cnt == 3) begin
          ic_rsp_valid <= 1'b1; ic_rsp_data <= cword(c_addr); c_pend <= 1'b0; c_cnt <= 0;
        end else c_cnt <= c_cnt + 1;
      end
      if (ic_req_valid && ic_req_ready) begin
        ic_req_ready <= 1'b0; c_pend <= 1'b1; c_addr <= ic_req_addr; c_cnt <= 0;
      end else if (ic_req_valid) begin
        if (c_cnt == 2) ic_req_ready <= 1'b1;
        c_cnt <= c_cnt + 1;
      end
    end
  end

  // monitors
  int mon_tcm, mon_port, mon_creq, n_mon_tcm, n_mon_port, n_mon_creq, n_mon_mnt;
  logic [AW-1:0] mon_off, mon_caddr, n_mon_off;
  always @(posedge clk) begin
    for (int k = 0; k < NT; k++) begin
      if (tcm_rd[k])   begin mon_tcm++;   mon_port = k;   mon_off = tcm_addr[k];     end
      if (n_tcm_rd[k]) begin n_mon_tcm++; n_mon_port = k; n_mon_off = n_tcm_addr[k]; end
    end
    if (ic_req_valid) mon_creq++;
    if (ic_req_valid && ic_req_ready) mon_caddr = ic_req_addr;
    if (n_ic_req_valid) n_mon_creq++;
    if (n_ic_mnt_valid) n_mon_mnt++;
  end

  int n_tests = 0, n_fail = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    mon_tcm = 0; mon_port = -1; mon_creq = 0; mon_off = '1; mon_caddr = '1;
    n_mon_tcm = 0; n_mon_port = -1; n_mon_off = '1;
  endtask

  task automatic do_fetch(input logic [AW-1:0] a, input int stall,
                          output logic [31:0] d, output logic e, output int lat);
    @(negedge clk);
    req_addr = a; req_valid = 1'b1; rsp_ready = (stall == 0);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; lat = 1;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    d = rsp_data; e = rsp_err;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk("R8 valid held", 32'(rsp_valid), 32'd1);
      chk("R8 data held", rsp_data, d);
      chk("R7 ready low while response waits", 32'(req_ready), 32'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
  endtask

  task automatic nc_fetch(input logic [AW-1:0] a,
                          output logic [31:0] d, output logic e, output int lat);
    @(negedge clk);
    n_req_addr = a; n_req_valid = 1'b1;
    while (!n_req_ready) @(negedge clk);
    @(negedge clk);
    n_req_valid = 1'b0; lat = 1;
    while (!n_rsp_valid) begin @(negedge clk); lat++; end
    d = n_rsp_data; e = n_rsp_err;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic        e;
    int          lat;
    logic [AW-1:0] off;
    clear_mon();
    n_mon_creq = 0; n_mon_mnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 req_ready", 32'(req_ready), 32'd1);
    chk("R12 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R12 tcm_rd", 32'(tcm_rd), 32'd0);
    chk("R12 ic_req_valid", 32'(ic_req_valid), 32'd0);
    chk("R12 ic_mnt_valid", 32'(ic_mnt_valid), 32'd0);

    // vector table: R1, R2, R4, R5
    for (int i = 0; i < 9; i++) begin
      logic [AW-1:0] a;
      int p;
      a = VEC[i][34:4];
      p = int'(VEC[i][1:0]);
      clear_mon();
      do_fetch(a, 0, d, e, lat);
      chk("R1/R4 err clear", 32'(e), 32'd0);
      if (VEC[i][3:2] == 2'd0) begin
        off = a & ((31'h1 << LGI_A[p]) - 31'h1);
        chk("R1 one strobe", 32'(mon_tcm), 32'd1);
        chk("R1 port", 32'(mon_port), 32'(p));
        chk("R1 offset", {1'b0, mon_off}, {1'b0, off});
        chk("R1 data", d, tword(p, off));
        chk("R1 latency", 32'(lat), 32'd2);
        chk("R2 cache untouched", 32'(mon_creq), 32'd0);
      end else begin
        chk("R4/R5 no strobe", 32'(mon_tcm), 32'd0);
        chk("R4 cache addr", {1'b0, mon_caddr}, {1'b0, a});
        chk("R4 data", d, cword(a));
      end
    end

    // R8, R7: back-pressure on a window fetch and a cache fetch
    clear_mon();
    do_fetch(31'h0001_0100, 3, d, e, lat);
    chk("R8 window data", d, tword(1, 31'h100));
    chk("R7 idle after handshake", 32'(req_ready), 32'd1);
    chk("R8 valid dropped", 32'(rsp_valid), 32'd0);
    clear_mon();
    do_fetch(31'h0300_0008, 2, d, e, lat);
    chk("R8 cache data", d, cword(31'h0300_0008));

    // R9 forward flush outside windows, R10 drop, R5 disabled window
    @(negedge clk); mreq_valid = 1'b1; mreq_op = 1'b1; mreq_addr = 31'h0040_0013;
    @(negedge clk); mreq_valid = 1'b0;
    chk("R9 flush forwarded", 32'(ic_mnt_valid), 32'd1);
    chk("R9 op", 32'(ic_mnt_op), 32'd1);
    chk("R9 aligned addr", {1'b0, ic_mnt_addr}, 32'h0040_0000);
    @(negedge clk);
    chk("R9 single pulse", 32'(ic_mnt_valid), 32'd0);
    mreq_valid = 1'b1; mreq_op = 1'b0; mreq_addr = 31'h0000_1FFF;
    @(negedge clk); mreq_valid = 1'b0;
    chk("R9 init forwarded", 32'(ic_mnt_valid), 32'd1);
    chk("R9 init op", 32'(ic_mnt_op), 32'd0);
    chk("R9 init addr", {1'b0, ic_mnt_addr}, 32'h0000_1FE0);
    @(negedge clk);
    mreq_valid = 1'b1; mreq_op = 1'b1; mreq_addr = 31'h0001_0040;
    @(negedge clk);
    chk("R10 flush in window dropped", 32'(ic_mnt_valid), 32'd0);
    mreq_op = 1'b0; mreq_addr = 31'h0010_0000;
    @(negedge clk); mreq_valid = 1'b0;
    chk("R10 init in window dropped", 32'(ic_mnt_valid), 32'd0);
    @(negedge clk);
    mreq_valid = 1'b1; mreq_op = 1'b0; mreq_addr = 31'h0020_0025;
    @(negedge clk); mreq_valid = 1'b0;
    chk("R5 disabled window forwarded", 32'(ic_mnt_valid), 32'd1);
    chk("R5 disabled window addr", {1'b0, ic_mnt_addr}, 32'h0020_0020);

    // cache-less instance: R3, R6, R11
    clear_mon();
    nc_fetch(31'h0000_0100, d, e, lat);
    chk("R3 overlap low port", 32'(n_mon_port), 32'd0);
    chk("R3 overlap data", d, tword(0, 31'h100));
    clear_mon();
    nc_fetch(31'h0000_2000, d, e, lat);
    chk("R3 outer window port", 32'(n_mon_port), 32'd1);
    chk("R3 outer window data", d, tword(1, 31'h2000));
    clear_mon();
    nc_fetch(31'h0005_0000, d, e, lat);
    chk("R6 error flag", 32'(e), 32'd1);
    chk("R6 zero data", d, 32'd0);
    chk("R6 latency", 32'(lat), 32'd1);
    chk("R6 no strobe", 32'(n_mon_tcm), 32'd0);
    @(negedge clk); n_mreq_valid = 1'b1; n_mreq_addr = 31'h0040_0000;
    @(negedge clk); n_mreq_valid = 1'b0;
    @(negedge clk);
    chk("R11 no maintenance out", 32'(n_mon_mnt), 32'd0);
    chk("R11 no cache request", 32'(n_mon_creq), 32'd0);

    summary();
  end
endmodule